// File: doc/BRIEF.md
# Transparent March RAM Self-Test Controller

This block is a hardware self-test engine for a word-wide single-port RAM. The RAM is divided into four equal segments. The top segment is kept as shadow storage and the application never uses it. A request names one of the three application segments. The controller first checks the shadow segment with a full march pass. It then saves the chosen segment into the shadow and confirms that the copy matches. Next it marches the chosen segment, writes the saved words back and confirms the restored copy. Because the original data returns to its place, the check can be run between application tasks and does not wait for a reset.

Two march variants can be selected. The long variant has six elements. The short variant drops the two middle elements and so takes fewer cycles. The first mismatch stops the run at once. The result is a two-bit cause code and the full address of the failing word, which software uses to move the system into a safe state. A request that names the shadow segment marches only the shadow. Choosing which segment to test, and when the application may be paused, is left to the system.

Top module: `tmarch_bist`

## Requirements
- R1: While reset is applied and in the first cycle after it, busy_o and done_o are low, err_code_o is 0, fail_addr_o is 0 and no RAM access is made.
- R2: start_i is accepted only when the controller is idle. A start_i pulse during a run does not restart it, change it or add a second done_o pulse.
- R3: For an application segment, the order is: march the shadow segment (3), copy the target to the shadow, verify the copy, march the target, copy the shadow back to the target, verify. After a passing run the target holds its original words.
- R4: With march_x_i = 0 the march elements are: write 0 ascending, read 0 and write 1 ascending, read 1 and write 0 ascending, read 0 and write 1 descending, read 1 and write 0 descending, read 0. One march takes 11N busy cycles for N words per segment, and a full run takes 32N.
- R5: With march_x_i = 1 the third and fourth elements are left out. One march takes 7N busy cycles and a full run takes 24N.
- R6: seg_sel_i = 3 marches only the shadow segment (11N or 7N busy cycles) and touches no other segment.
- R7: A march read that differs from all-zeros or all-ones (whichever the element expects) ends the run with err_code_o = 1 and fail_addr_o = that word's address.
- R8: A mismatch while verifying the saved copy ends the run with err_code_o = 2 and fail_addr_o = the shadow word's address.
- R9: A mismatch while verifying the restored data ends the run with err_code_o = 3 and fail_addr_o = the target word's address.
- R10: done_o is high for exactly one cycle, with busy_o low, at the end of each run. err_code_o (0 = pass) and fail_addr_o hold until the next accepted start, which clears them.
- R11: The RAM port gives read data one cycle after a read. ram_we_o is only high together with ram_en_o, and the port is quiet while the controller is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a test run |
| seg_sel_i | input | 2 | Segment to test (3 = shadow only) |
| march_x_i | input | 1 | 1 selects the shortened march |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | SEG_AW+2 | RAM word address {segment, index} |
| ram_wdata_o | output | DW | RAM write data |
| ram_rdata_i | input | DW | RAM read data, one cycle after a read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_code_o | output | 2 | 0 pass, 1 march, 2 save verify, 3 restore verify |
| fail_addr_o | output | SEG_AW+2 | Address of the first failing word |

## Verification
The copy-verify failures are the hardest cases to reach. A solid-background march never writes a value that could expose a word which fails only for mixed data, so a stuck bit will never reach a verify stage. The bench RAM model therefore includes a data-sensitive write fault: it flips one bit only when a non-solid word is written to a chosen address. Placed in the shadow segment, this fault fails the save verify. Placed in the target segment, it fails only the restore verify. Stuck-at read faults in the target and in the shadow cover the march aborts. In every failing run the exact busy-cycle count shows the element order up to the failure.

// File: rtl/tmarch_pkg.sv
`timescale 1ns/1ps
package tmarch_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_W0, PH_R0W1_UP, PH_R1W0_UP, PH_R0W1_DN, PH_R1W0_DN,
    PH_R0, PH_SAVE, PH_VSAVE, PH_REST, PH_VREST, PH_DONE
  } phase_t;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0, ERR_MARCH = 2'd1, ERR_SAVE = 2'd2, ERR_RESTORE = 2'd3
  } err_t;

  localparam int unsigned SEG_SEL_W = 2;
  localparam logic [SEG_SEL_W-1:0] SHADOW_SEG = 2'd3;

  // last sub-step index of a per-word operation in each phase
  function automatic logic [1:0] last_sub(input phase_t ph);
    case (ph)
      PH_W0:              return 2'd0;
      PH_VSAVE, PH_VREST: return 2'd2;
      default:            return 2'd1;
    endcase
  endfunction

  function automatic logic is_down(input phase_t ph);
    return (ph == PH_R0W1_DN) || (ph == PH_R1W0_DN);
  endfunction

  function automatic logic expects_ones(input phase_t ph);
    return (ph == PH_R1W0_UP) || (ph == PH_R1W0_DN);
  endfunction

  function automatic logic is_march_read(input phase_t ph);
    return (ph == PH_R0W1_UP) || (ph == PH_R1W0_UP) || (ph == PH_R0W1_DN) ||
           (ph == PH_R1W0_DN) || (ph == PH_R0);
  endfunction

  function automatic logic is_verify(input phase_t ph);
    return (ph == PH_VSAVE) || (ph == PH_VREST);
  endfunction

  function automatic logic from_target(input phase_t ph);
    return (ph == PH_SAVE) || (ph == PH_VSAVE);
  endfunction

endpackage

// File: rtl/tmarch_addr_gen.sv
`timescale 1ns/1ps
module tmarch_addr_gen #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          down_i,
  input  logic          step_i,
  output logic [AW-1:0] idx_o,
  output logic          last_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] idx_q, idx_d;
  logic          down_q, down_d;

  always_comb begin
    idx_d  = idx_q;
    down_d = down_q;
    if (load_i) begin
      down_d = down_i;
      idx_d  = down_i ? '1 : '0;
    end else if (step_i) begin
      idx_d = down_q ? (idx_q - ONE) : (idx_q + ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      down_q <= 1'b0;
    end else if (load_i || step_i) begin
      idx_q  <= idx_d;
      down_q <= down_d;
    end
  end

  assign idx_o  = idx_q;
  assign last_o = down_q ? (idx_q == '0) : (idx_q == '1);
endmodule

// File: rtl/tmarch_ctrl.sv
`timescale 1ns/1ps
module tmarch_ctrl
  import tmarch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [SEG_SEL_W-1:0] seg_sel_i,
  input  logic                 march_x_i,
  input  logic                 last_i,
  input  logic                 mismatch_i,
  output phase_t               phase_o,
  output logic [1:0]           sub_o,
  output logic [SEG_SEL_W-1:0] mseg_o,
  output logic [SEG_SEL_W-1:0] tgt_o,
  output logic                 load_o,
  output logic                 down_o,
  output logic                 step_o,
  output logic                 accept_o
);
  phase_t                 phase_q, phase_d;
  logic [1:0]             sub_q, sub_d;
  logic [SEG_SEL_W-1:0]   mseg_q, mseg_d, tgt_q, tgt_d;
  logic                   xmode_q, xmode_d;

  always_comb begin
    phase_d  = phase_q;
    sub_d    = sub_q;
    mseg_d   = mseg_q;
    tgt_d    = tgt_q;
    xmode_d  = xmode_q;
    load_o   = 1'b0;
    step_o   = 1'b0;
    accept_o = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          phase_d  = PH_W0;
          sub_d    = 2'd0;
          mseg_d   = SHADOW_SEG;       // shadow is always checked first
          tgt_d    = seg_sel_i;
          xmode_d  = march_x_i;
          load_o   = 1'b1;
        end
      end
      PH_DONE: phase_d = PH_IDLE;
      default: begin
        if (mismatch_i) begin
          phase_d = PH_DONE;
          sub_d   = 2'd0;
        end else if (sub_q != last_sub(phase_q)) begin
          sub_d = sub_q + 2'd1;
        end else begin
          sub_d = 2'd0;
          if (!last_i) begin
            step_o = 1'b1;
          end else begin
            load_o = 1'b1;
            case (phase_q)
              PH_W0:      phase_d = PH_R0W1_UP;
              PH_R0W1_UP: phase_d = xmode_q ? PH_R1W0_DN : PH_R1W0_UP;
              PH_R1W0_UP: phase_d = PH_R0W1_DN;
              PH_R0W1_DN: phase_d = PH_R1W0_DN;
              PH_R1W0_DN: phase_d = PH_R0;
              PH_R0: begin
                if (mseg_q != SHADOW_SEG)      phase_d = PH_REST;
                else if (tgt_q == SHADOW_SEG)  phase_d = PH_DONE;
                else                           phase_d = PH_SAVE;
              end
              PH_SAVE:  phase_d = PH_VSAVE;
              PH_VSAVE: begin
                phase_d = PH_W0;
                mseg_d  = tgt_q;
              end
              PH_REST:  phase_d = PH_VREST;
              default:  phase_d = PH_DONE;
            endcase
          end
        end
      end
    endcase
    down_o = is_down(phase_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sub_q   <= 2'd0;
      mseg_q  <= '0;
      tgt_q   <= '0;
      xmode_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      sub_q   <= sub_d;
      mseg_q  <= mseg_d;
      tgt_q   <= tgt_d;
      xmode_q <= xmode_d;
    end
  end

  assign phase_o = phase_q;
  assign sub_o   = sub_q;
  assign mseg_o  = mseg_q;
  assign tgt_o   = tgt_q;
endmodule

// File: rtl/tmarch_err_capture.sv
`timescale 1ns/1ps
module tmarch_err_capture
  import tmarch_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          set_i,
  input  err_t          code_i,
  input  logic [AW-1:0] addr_i,
  output err_t          code_o,
  output logic [AW-1:0] addr_o
);
  err_t          code_q;
  logic [AW-1:0] addr_q;
  logic          upd;

  assign upd = clear_i || set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= ERR_NONE;
      addr_q <= '0;
    end else if (upd) begin
      code_q <= clear_i ? ERR_NONE : code_i;
      addr_q <= clear_i ? '0 : addr_i;
    end
  end

  assign code_o = code_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/tmarch_bist.sv
`timescale 1ns/1ps
module tmarch_bist
  import tmarch_pkg::*;
#(
  parameter int unsigned SEG_AW = 4,
  parameter int unsigned DW     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [1:0]               seg_sel_i,
  input  logic                     march_x_i,
  output logic                     ram_en_o,
  output logic                     ram_we_o,
  output logic [SEG_AW+1:0]        ram_addr_o,
  output logic [DW-1:0]            ram_wdata_o,
  input  logic [DW-1:0]            ram_rdata_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [1:0]               err_code_o,
  output logic [SEG_AW+1:0]        fail_addr_o
);
  localparam int unsigned ADDR_W = SEG_AW + SEG_SEL_W;

  phase_t               phase;
  logic [1:0]           sub;
  logic [SEG_SEL_W-1:0] mseg, tgt, src_seg, dst_seg, acc_seg, fail_seg;
  logic                 load, down, step, accept, last;
  logic [SEG_AW-1:0]    idx;
  logic                 mismatch;
  err_t                 cmp_code, cap_code;
  logic [DW-1:0]        hold_q;
  logic                 hold_en;

  tmarch_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .seg_sel_i  (seg_sel_i),
    .march_x_i  (march_x_i),
    .last_i     (last),
    .mismatch_i (mismatch),
    .phase_o    (phase),
    .sub_o      (sub),
    .mseg_o     (mseg),
    .tgt_o      (tgt),
    .load_o     (load),
    .down_o     (down),
    .step_o     (step),
    .accept_o   (accept)
  );

  tmarch_addr_gen #(.AW(SEG_AW)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .down_i (down),
    .step_i (step),
    .idx_o  (idx),
    .last_o (last)
  );

  assign src_seg = from_target(phase) ? tgt : SHADOW_SEG;
  assign dst_seg = from_target(phase) ? SHADOW_SEG : tgt;

  // first word of a verify pair is held for comparison with the second
  assign hold_en = is_verify(phase) && (sub == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= ram_rdata_i;
    end
  end

  always_comb begin
    mismatch = 1'b0;
    cmp_code = ERR_NONE;
    fail_seg = mseg;
    if (is_march_read(phase) && (sub == 2'd1)) begin
      mismatch = ram_rdata_i != (expects_ones(phase) ? {DW{1'b1}} : {DW{1'b0}});
      cmp_code = ERR_MARCH;
    end else if (is_verify(phase) && (sub == 2'd2)) begin
      mismatch = ram_rdata_i != hold_q;
      cmp_code = from_target(phase) ? ERR_SAVE : ERR_RESTORE;
      fail_seg = dst_seg;
    end
  end

  tmarch_err_capture #(.AW(ADDR_W)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .set_i   (mismatch),
    .code_i  (cmp_code),
    .addr_i  ({fail_seg, idx}),
    .code_o  (cap_code),
    .addr_o  (fail_addr_o)
  );

  always_comb begin
    ram_en_o    = 1'b0;
    ram_we_o    = 1'b0;
    acc_seg     = mseg;
    ram_wdata_o = '0;
    case (phase)
      PH_W0: begin
        ram_en_o = 1'b1;
        ram_we_o = 1'b1;
      end
      PH_R0W1_UP, PH_R1W0_UP, PH_R0W1_DN, PH_R1W0_DN: begin
        ram_en_o    = 1'b1;
        ram_we_o    = (sub == 2'd1);
        ram_wdata_o = expects_ones(phase) ? {DW{1'b0}} : {DW{1'b1}};
      end
      PH_R0: ram_en_o = (sub == 2'd0);
      PH_SAVE, PH_REST: begin
        ram_en_o    = 1'b1;
        ram_we_o    = (sub == 2'd1);
        acc_seg     = (sub == 2'd0) ? src_seg : dst_seg;
        ram_wdata_o = ram_rdata_i;
      end
      PH_VSAVE, PH_VREST: begin
        ram_en_o = (sub != 2'd2);
        acc_seg  = (sub == 2'd0) ? src_seg : dst_seg;
      end
      default: ;
    endcase
  end

  assign ram_addr_o = {acc_seg, idx};
  assign busy_o     = (phase != PH_IDLE) && (phase != PH_DONE);
  assign done_o     = (phase == PH_DONE);
  assign err_code_o = cap_code;
endmodule

// File: rtl/tmarch_bist_sva.sv
`timescale 1ns/1ps
module tmarch_bist_sva
  import tmarch_pkg::*;
#(
  parameter int unsigned SEG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [1:0]        seg_sel_i,
  input logic              ram_en_o,
  input logic              ram_we_o,
  input logic [SEG_AW+1:0] ram_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        err_code_o,
  input logic [SEG_AW+1:0] fail_addr_o
);
  localparam int unsigned ADDR_W = SEG_AW + 2;

  logic [1:0] tgt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q <= 2'd0;
    else if (start_i && !busy_o && !done_o) tgt_q <= seg_sel_i;
  end

  a_r11_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> ram_en_o);
  a_r11_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !ram_en_o);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r10_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o) |=> (busy_o || $stable(err_code_o)));
  a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o) |=> (busy_o || $stable(fail_addr_o)));
  a_r7_fail_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code_o != 2'd0) |-> !busy_o);
  a_r2_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));
  a_r6_segment_confined: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en_o |-> ((ram_addr_o[ADDR_W-1 -: 2] == SHADOW_SEG) ||
                  (ram_addr_o[ADDR_W-1 -: 2] == tgt_q)));
endmodule

bind tmarch_bist tmarch_bist_sva #(.SEG_AW(SEG_AW)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .seg_sel_i   (seg_sel_i),
  .ram_en_o    (ram_en_o),
  .ram_we_o    (ram_we_o),
  .ram_addr_o  (ram_addr_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_code_o  (err_code_o),
  .fail_addr_o (fail_addr_o)
);

// File: tb/tmarch_bist_test.sv
`timescale 1ns/1ps
module tmarch_bist_test;
  localparam int SEG_AW = 4;
  localparam int DW     = 8;
  localparam int AW     = SEG_AW + 2;
  localparam int N      = 1 << SEG_AW;
  localparam int WORDS  = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, start, march_x;
  logic [1:0]    seg_sel;
  logic          ram_en, ram_we, busy, done;
  logic [AW-1:0] ram_addr, fail_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;
  logic [1:0]    err_code;

  tmarch_bist #(.SEG_AW(SEG_AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .seg_sel_i(seg_sel),
    .march_x_i(march_x), .ram_en_o(ram_en), .ram_we_o(ram_we),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .busy_o(busy), .done_o(done), .err_code_o(err_code), .fail_addr_o(fail_addr)
  );

  // RAM model with fault knobs
  logic [DW-1:0] mem [WORDS];
  logic          init_req = 1'b0;
  logic          sa_on = 1'b0, pf_on = 1'b0;
  logic [AW-1:0] sa_addr = '0, pf_addr = '0;
  logic [DW-1:0] sa1_mask = '0, sa0_mask = '0;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 29 + 7);
  endfunction

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= pat(i);
    end else if (ram_en) begin
      if (ram_we) begin
        if (pf_on && ram_addr == pf_addr && ram_wdata != '0 && ram_wdata != '1)
          mem[ram_addr] <= ram_wdata ^ 8'h01;
        else
          mem[ram_addr] <= ram_wdata;
      end else if (sa_on && ram_addr == sa_addr) begin
        ram_rdata <= (mem[ram_addr] | sa1_mask) & ~sa0_mask;
      end else begin
        ram_rdata <= mem[ram_addr];
      end
    end
  end

  // scoreboard
  typedef struct {
    logic [1:0]    code;
    logic [AW-1:0] addr;
    int            cycles;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  int checks = 0, fails = 0, busy_cnt = 0;
  logic done_prev = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (done && done_prev) check(1'b0, "R10", "done wider than one cycle", 2, 1);
      if (done) begin
        check(!busy, "R10", "busy during done", int'(busy), 0);
        if (sb_q.size() == 0) begin
          check(1'b0, "R2", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(err_code == e.code, e.tag, "error code", int'(err_code), int'(e.code));
          check(fail_addr == e.addr, e.tag, "fail address", int'(fail_addr), int'(e.addr));
          if (e.cycles > 0)
            check(busy_cnt == e.cycles, e.tag, "busy cycles", busy_cnt, e.cycles);
        end
        busy_cnt = 0;
      end
      done_prev = done;
    end
  end

  task automatic load_mem();
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
  endtask

  task automatic run_job(input logic [1:0] seg, input logic x, input logic [1:0] code,
                         input logic [AW-1:0] addr, input int cycles,
                         input string tag, input int poke_at);
    exp_t e;
    int n;
    e.code = code; e.addr = addr; e.cycles = cycles; e.tag = tag;
    sb_q.push_back(e);
    seg_sel = seg; march_x = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin
      if (n == poke_at) begin
        start = 1'b1; seg_sel = 2'd2; march_x = ~x;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (n >= 3000) check(1'b0, tag, "run timeout", n, 0);
    repeat (4) @(negedge clk);
    check(err_code == code, "R10", "code held after done", int'(err_code), int'(code));
    check(!ram_en, "R11", "port quiet after run", int'(ram_en), 0);
  endtask

  task automatic check_seg(input int seg, input string tag);
    int bad = 0;
    for (int i = 0; i < N; i++)
      if (mem[seg*N + i] != pat(seg*N + i)) bad++;
    check(bad == 0, tag, $sformatf("changed words in segment %0d", seg), bad, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; seg_sel = 2'd0; march_x = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1", "busy/done in reset", int'(busy) + int'(done), 0);
    check(err_code == 2'd0, "R1", "code in reset", int'(err_code), 0);
    check(!ram_en, "R11", "access in reset", int'(ram_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && fail_addr == '0, "R1", "state after reset",
          int'(busy) + int'(done) + int'(fail_addr), 0);

    // full long run on segment 0
    load_mem();
    run_job(2'd0, 1'b0, 2'd0, '0, 32*N, "R4", -1);
    check_seg(0, "R3"); check_seg(1, "R3"); check_seg(2, "R3");

    // short run on segment 2
    load_mem();
    run_job(2'd2, 1'b1, 2'd0, '0, 24*N, "R5", -1);
    check_seg(2, "R5");

    // shadow-only requests
    load_mem();
    run_job(2'd3, 1'b0, 2'd0, '0, 11*N, "R6", -1);
    check_seg(0, "R6"); check_seg(1, "R6"); check_seg(2, "R6");
    run_job(2'd3, 1'b1, 2'd0, '0, 7*N, "R6", -1);

    // start during a run is ignored
    load_mem();
    run_job(2'd1, 1'b0, 2'd0, '0, 32*N, "R2", 40);
    check_seg(1, "R2");
    repeat (60) @(negedge clk);
    check(!busy, "R2", "restarted by ignored start", int'(busy), 0);

    // stuck-at-1 bit 3 in target word 5: march abort after save/verify
    load_mem();
    sa_on = 1'b1; sa_addr = 6'd5; sa1_mask = 8'h08; sa0_mask = 8'h00;
    run_job(2'd0, 1'b0, 2'd1, 6'd5, 11*N + 5*N + N + 12, "R7", -1);
    sa_on = 1'b0;

    // stuck-at-0 bit 0 in shadow word 50: shadow march fails first (short mode)
    load_mem();
    sa_on = 1'b1; sa_addr = 6'd50; sa1_mask = 8'h00; sa0_mask = 8'h01;
    run_job(2'd1, 1'b1, 2'd1, 6'd50, N + 2*N + 28, "R3", -1);
    sa_on = 1'b0;
    check_seg(1, "R3");

    // data-sensitive write fault in shadow word 55: save verify fails
    load_mem();
    pf_on = 1'b1; pf_addr = 6'd55;
    run_job(2'd1, 1'b0, 2'd2, 6'd55, 11*N + 2*N + 24, "R8", -1);
    check_seg(1, "R8");

    // data-sensitive write fault in target word 41: restore verify fails
    load_mem();
    pf_addr = 6'd41;
    run_job(2'd2, 1'b0, 2'd3, 6'd41, 11*N + 5*N + 11*N + 2*N + 30, "R9", -1);
    pf_on = 1'b0;

    // result cleared by the next accepted start
    load_mem();
    run_job(2'd0, 1'b1, 2'd0, '0, 24*N, "R10", -1);
    check_seg(0, "R10");

    check(sb_q.size() == 0, "R2", "missing done pulses", sb_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #600000;
    check(1'b0, "WD", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule